// File: doc/BRIEF.md
# Flash Command Sequence and Protection Controller

This block sits behind the synchronous command pins of a flash part that shares its pinout with an SDRAM. Each clock it turns the four active-low strobes (chip select, row strobe, column strobe, write enable) into one command. It then follows the three-step operation sequences such a part uses. A load-command cycle carries an operation code on the low address byte. An ACTIVE cycle follows, which here opens no row. A WRITE cycle then carries confirm data. NOP and inhibit cycles may fall between the steps. The bank must be the same in all three steps.

The controller holds the protection state: one device-wide lock bit and sixteen block lock bits. Depending on a high-voltage override input, the code and the confirm byte, a completed sequence does one of four things. It updates those bits, starts a self-timed operation (modelled by a busy counter), is refused, or is flagged as a bad confirm. A load-command cycle also picks what the read path returns: array data, the status byte or the configuration space. Array contents, pump timing and burst reads belong to other blocks.

Top module: `flash_seq_ctrl`

## Requirements
- R1: Commands decode from {cs_n,ras_n,cas_n,we_n}: 1xxx inhibit, 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 burst stop, 0010 active stop, 0001 load-command, 0000 load-mode. An ACTIVE received while no sequence is open raises `row_open` for exactly the following cycle. No other command raises it.
- R2: A load-command cycle received while no sequence is open sets `read_path`. Code 70h gives 1 (status), 90h gives 2 (configuration), and any other code gives 0 (array). Code 50h also clears both error bits of the status byte.
- R3: Codes 20h (erase), 40h (program), 60h (lock/unlock), 30h (store-mode erase) and A0h (store-mode program) open a sequence. The ACTIVE of that sequence leaves `row_open` low.
- R4: A sequence acts only if the ACTIVE and the WRITE carry the same bank as the load-command cycle. NOP and inhibit cycles between the steps keep the sequence open. A bank mismatch closes it with no effect on any output.
- R5: Any command other than NOP or inhibit that arrives where the next step is expected closes the sequence with no effect. The command itself is not acted on.
- R6: Confirm bytes are: erase D0h; lock block 01h; lock device F1h; unlock all D0h; store-mode erase C0h. Program and store-mode program take any byte. A wrong confirm sets status bit 5 and starts nothing.
- R7: A lock-block sequence sets `block_lock` bit {bank, addr[11:10]}, taken from the ACTIVE step.
- R8: Lock-device (F1h) sets `device_lock` only when `hv_override` is high during the WRITE step. Otherwise it sets status bit 4 (refused).
- R9: With `device_lock` set and `hv_override` low, erase, program, lock-block and unlock are refused: status bit 4 is set, `block_lock` stays unchanged and nothing starts. With `hv_override` low, erase or program of a block whose lock bit is set is also refused.
- R10: Unlock with `hv_override` low clears every block lock bit except bits 0 and 15. With `hv_override` high it clears all sixteen, whatever `device_lock` holds.
- R11: An accepted operation drives status bit 7 (ready) low for exactly BUSY_CYCLES cycles, starting at its WRITE edge. A sequence confirmed while ready is low is dropped with no effect.
- R12: While `rst_n` is low: the status byte becomes 80h, `read_path` becomes 0, any open sequence closes, the busy counter clears, and all lock bits clear. Status bits other than 7, 5 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank | input | 2 | Bank select |
| addr | input | 12 | Address; low byte is the code on load-command cycles |
| din | input | 8 | Data byte used as confirm on the WRITE step |
| hv_override | input | 1 | High-voltage override level |
| row_open | output | 1 | One-cycle pulse after a plain ACTIVE |
| read_path | output | 2 | 0 array, 1 status, 2 configuration |
| status | output | 8 | Bit 7 ready, bit 5 bad confirm, bit 4 refused |
| device_lock | output | 1 | Device-wide lock bit |
| block_lock | output | 16 | Per-block lock bits |

## Verification
The bench locks each of the sixteen blocks in turn, each time from a different bank and row pair. A design with the block index bits swapped would set the wrong bit of the accumulating mask. Unlock is run once without the override and once with it. A design that treated blocks 0 and 15 like the rest, or that ignored the level, would leave the wrong residue. Sequences are broken by a wrong bank, by an interleaved READ and by arriving during busy. A controller that did not abandon or drop them would change lock bits or restart the timer. The busy window is counted cycle by cycle, and refusals under the device lock are checked against lock bits that must stay unchanged.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NBLK   = 16;
  localparam int BANK_W = 2;
  localparam int ADDR_W = 12;
  localparam int CODE_W = 8;
  localparam int BIDX_W = BANK_W + 2;

  typedef enum logic [3:0] {
    C_INHIBIT, C_NOP, C_ACTIVE, C_READ, C_WRITE,
    C_BSTOP, C_ASTOP, C_LCR, C_LMR
  } cmd_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT_ACT, SQ_WAIT_WR} seq_e;

  localparam logic [7:0] OP_RD_CFG  = 8'h90;
  localparam logic [7:0] OP_RD_STAT = 8'h70;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_NV_ER   = 8'h30;
  localparam logic [7:0] OP_NV_PR   = 8'hA0;

  localparam logic [7:0] CF_GO      = 8'hD0;
  localparam logic [7:0] CF_BLK     = 8'h01;
  localparam logic [7:0] CF_DEV     = 8'hF1;
  localparam logic [7:0] CF_NV_ER   = 8'hC0;

  function automatic cmd_e decode_cmd(input logic cs_n, ras_n, cas_n, we_n);
    if (cs_n) return C_INHIBIT;
    case ({ras_n, cas_n, we_n})
      3'b111:  return C_NOP;
      3'b011:  return C_ACTIVE;
      3'b101:  return C_READ;
      3'b100:  return C_WRITE;
      3'b110:  return C_BSTOP;
      3'b010:  return C_ASTOP;
      3'b001:  return C_LCR;
      default: return C_LMR;
    endcase
  endfunction

  function automatic logic opens_seq(input logic [7:0] code);
    return code == OP_ERASE || code == OP_PROG || code == OP_LOCK ||
           code == OP_NV_ER || code == OP_NV_PR;
  endfunction

  function automatic logic [BIDX_W-1:0] blk_index(input logic [BANK_W-1:0] b,
                                                  input logic [1:0] row_hi);
    return {b, row_hi};
  endfunction

  // Bits that survive an unlock: the two end blocks unless overridden.
  function automatic logic [NBLK-1:0] unlock_keep(input logic hv);
    logic [NBLK-1:0] k;
    k = '0;
    if (!hv) begin
      k[0]      = 1'b1;
      k[NBLK-1] = 1'b1;
    end
    return k;
  endfunction

  function automatic logic [1:0] path_for(input logic [7:0] code);
    if (code == OP_RD_STAT) return 2'd1;
    if (code == OP_RD_CFG)  return 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
  import fsc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd,
  output logic is_idle_cmd
);
  always_comb begin
    cmd         = decode_cmd(cs_n, ras_n, cas_n, we_n);
    is_idle_cmd = (cmd == C_NOP) || (cmd == C_INHIBIT);
  end
endmodule

// File: rtl/fsc_seq_fsm.sv
module fsc_seq_fsm
  import fsc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  cmd_e                     cmd,
  input  logic                     is_idle_cmd,
  input  logic [BANK_W-1:0]        bank,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     lcr_now,
  output logic [CODE_W-1:0]        lcr_code,
  output logic                     exec,
  output logic [CODE_W-1:0]        exec_code,
  output logic [BIDX_W-1:0]        exec_blk,
  output logic                     row_open
);
  seq_e              state_q;
  logic [CODE_W-1:0] code_q;
  logic [BANK_W-1:0] bank_q;
  logic [1:0]        rowhi_q;
  logic              row_open_q;
  logic              bank_hit;
  logic              unused_addr;

  assign unused_addr = ^addr[9:8];
  assign bank_hit  = (bank == bank_q);
  assign lcr_now   = (state_q == SQ_IDLE) && (cmd == C_LCR);
  assign lcr_code  = addr[CODE_W-1:0];
  assign exec      = (state_q == SQ_WAIT_WR) && (cmd == C_WRITE) && bank_hit;
  assign exec_code = code_q;
  assign exec_blk  = blk_index(bank_q, rowhi_q);
  assign row_open  = row_open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      code_q     <= '0;
      bank_q     <= '0;
      rowhi_q    <= '0;
      row_open_q <= 1'b0;
    end else begin
      row_open_q <= (state_q == SQ_IDLE) && (cmd == C_ACTIVE);
      case (state_q)
        SQ_IDLE: if (lcr_now && opens_seq(lcr_code)) begin
          state_q <= SQ_WAIT_ACT;
          code_q  <= lcr_code;
          bank_q  <= bank;
        end
        SQ_WAIT_ACT: if (!is_idle_cmd) begin
          if (cmd == C_ACTIVE && bank_hit) begin
            state_q <= SQ_WAIT_WR;
            rowhi_q <= addr[ADDR_W-1:ADDR_W-2];
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        SQ_WAIT_WR: if (!is_idle_cmd) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assert_seq_active_no_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |=> !row_open_q);
  assert_exec_from_open_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec |-> $past(state_q != SQ_IDLE));
endmodule

// File: rtl/fsc_busy_timer.sv
module fsc_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign ready = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CW'(BUSY_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assert_start_goes_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);
  assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ready);
endmodule

// File: rtl/fsc_protect.sv
module fsc_protect
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcr_now,
  input  logic [CODE_W-1:0] lcr_code,
  input  logic              exec,
  input  logic [CODE_W-1:0] exec_code,
  input  logic [BIDX_W-1:0] exec_blk,
  input  logic [7:0]        din,
  input  logic              hv_override,
  input  logic              ready,
  output logic              start,
  output logic              device_lock,
  output logic [NBLK-1:0]   block_lock,
  output logic              err_conf,
  output logic              err_ref,
  output logic [1:0]        read_path
);
  logic            dev_q, econf_q, eref_q;
  logic [NBLK-1:0] blk_q;
  logic [1:0]      path_q;
  logic            ok_c, bad_c, ref_c, dev_set_c;
  logic [NBLK-1:0] blk_n;
  logic            allow, tgt_locked, act;

  assign allow      = !dev_q || hv_override;
  assign tgt_locked = blk_q[exec_blk] && !hv_override;
  assign act        = exec && ready;

  always_comb begin
    ok_c = 1'b0; bad_c = 1'b0; ref_c = 1'b0; dev_set_c = 1'b0;
    blk_n = blk_q;
    case (exec_code)
      OP_ERASE: begin
        if (din != CF_GO)                bad_c = 1'b1;
        else if (!allow || tgt_locked)   ref_c = 1'b1;
        else                             ok_c  = 1'b1;
      end
      OP_PROG: begin
        if (!allow || tgt_locked) ref_c = 1'b1;
        else                      ok_c  = 1'b1;
      end
      OP_LOCK: begin
        case (din)
          CF_BLK: if (allow) begin ok_c = 1'b1; blk_n[exec_blk] = 1'b1; end
                  else ref_c = 1'b1;
          CF_DEV: if (hv_override) begin ok_c = 1'b1; dev_set_c = 1'b1; end
                  else ref_c = 1'b1;
          CF_GO:  if (allow) begin ok_c = 1'b1; blk_n = blk_q & unlock_keep(hv_override); end
                  else ref_c = 1'b1;
          default: bad_c = 1'b1;
        endcase
      end
      OP_NV_ER: if (din == CF_NV_ER) ok_c = 1'b1; else bad_c = 1'b1;
      default:  ok_c = 1'b1;
    endcase
  end

  assign start       = act && ok_c;
  assign device_lock = dev_q;
  assign block_lock  = blk_q;
  assign err_conf    = econf_q;
  assign err_ref     = eref_q;
  assign read_path   = path_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q <= 1'b0; blk_q <= '0; econf_q <= 1'b0; eref_q <= 1'b0; path_q <= 2'd0;
    end else begin
      if (lcr_now) begin
        path_q <= path_for(lcr_code);
        if (lcr_code == OP_CLR) begin
          econf_q <= 1'b0;
          eref_q  <= 1'b0;
        end
      end
      if (act) begin
        if (bad_c) econf_q <= 1'b1;
        if (ref_c) eref_q  <= 1'b1;
        if (ok_c) begin
          blk_q <= blk_n;
          if (dev_set_c) dev_q <= 1'b1;
        end
      end
    end
  end

  assert_dev_lock_needs_hv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_q) |-> $past(hv_override));
  assert_end_blocks_need_hv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blk_q[0]) || $fell(blk_q[NBLK-1])) |-> $past(hv_override));
  assert_locked_bits_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_q && !hv_override) |=> $stable(blk_q));
  assert_single_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec |-> $countones({ok_c, bad_c, ref_c}) == 1);
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fsc_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  bank,
  input  logic [11:0] addr,
  input  logic [7:0]  din,
  input  logic        hv_override,
  output logic        row_open,
  output logic [1:0]  read_path,
  output logic [7:0]  status,
  output logic        device_lock,
  output logic [15:0] block_lock
);
  cmd_e              cmd;
  logic              is_idle_cmd;
  logic              lcr_now, exec, start, ready, err_conf, err_ref;
  logic [CODE_W-1:0] lcr_code, exec_code;
  logic [BIDX_W-1:0] exec_blk;

  fsc_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd), .is_idle_cmd(is_idle_cmd)
  );

  fsc_seq_fsm u_seq (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .is_idle_cmd(is_idle_cmd),
    .bank(bank), .addr(addr), .lcr_now(lcr_now), .lcr_code(lcr_code),
    .exec(exec), .exec_code(exec_code), .exec_blk(exec_blk), .row_open(row_open)
  );

  fsc_protect u_prot (
    .clk(clk), .rst_n(rst_n), .lcr_now(lcr_now), .lcr_code(lcr_code),
    .exec(exec), .exec_code(exec_code), .exec_blk(exec_blk), .din(din),
    .hv_override(hv_override), .ready(ready), .start(start),
    .device_lock(device_lock), .block_lock(block_lock),
    .err_conf(err_conf), .err_ref(err_ref), .read_path(read_path)
  );

  fsc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready)
  );

  assign status = {ready, 1'b0, err_conf, err_ref, 4'b0000};

  assert_row_pulse_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    row_open |=> !row_open || $past(cmd == C_ACTIVE));
endmodule

// File: tb/sim_flash_seq_ctrl.sv
module sim_flash_seq_ctrl;
  localparam int BUSY = 16;
  localparam logic [3:0] K_INH = 4'b1111, K_NOP = 4'b0111, K_ACT = 4'b0011,
                         K_RD = 4'b0101, K_WR = 4'b0100, K_LCR = 4'b0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, hv_override;
  logic [1:0] bank;
  logic [11:0] addr;
  logic [7:0] din;
  logic row_open, device_lock;
  logic [1:0] read_path;
  logic [7:0] status;
  logic [15:0] block_lock;
  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] exp_blk;

  always #10 clk = ~clk;

  flash_seq_ctrl #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .addr(addr), .din(din), .hv_override(hv_override),
    .row_open(row_open), .read_path(read_path), .status(status),
    .device_lock(device_lock), .block_lock(block_lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drv(input logic [3:0] c, input logic [1:0] b,
                     input logic [11:0] a, input logic [7:0] d);
    {cs_n, ras_n, cas_n, we_n} = c;
    bank = b; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle_in();
    {cs_n, ras_n, cas_n, we_n} = K_NOP;
    bank = 2'd0; addr = 12'd0; din = 8'd0;
  endtask

  task automatic seq3(input logic [7:0] code, input logic [3:0] blk, input logic [7:0] d);
    drv(K_LCR, blk[3:2], {4'h0, code}, 8'h00);
    drv(K_ACT, blk[3:2], {blk[1:0], 10'h0}, 8'h00);
    drv(K_WR,  blk[3:2], 12'h000, d);
    idle_in();
  endtask

  task automatic wait_ready(inout int n);
    for (int i = 0; i < 1000 && status[7] == 1'b0; i++) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clr_status();
    drv(K_LCR, 2'd0, 12'h050, 8'h00);
    idle_in();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    idle_in();
    hv_override = 1'b0;
    exp_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 status", status, 8'h80);
    chk("R12 read_path", read_path, 0);
    chk("R12 locks", {device_lock, block_lock}, 0);

    // R1 plain ACTIVE pulses row_open for one cycle
    drv(K_ACT, 2'd1, 12'h005, 8'h00);
    chk("R1 active row_open", row_open, 1);
    drv(K_RD, 2'd1, 12'h005, 8'h00);
    chk("R1 read no row_open", row_open, 0);
    drv(K_INH, 2'd0, 12'h000, 8'h00);
    chk("R1 inhibit no row_open", row_open, 0);

    // R2 read path selection
    drv(K_LCR, 2'd0, 12'h070, 8'h00); idle_in();
    chk("R2 status path", read_path, 1);
    drv(K_LCR, 2'd0, 12'h090, 8'h00); idle_in();
    chk("R2 config path", read_path, 2);
    drv(K_LCR, 2'd0, 12'h0FF, 8'h00); idle_in();
    chk("R2 array path", read_path, 0);

    // R7 sweep all blocks, with idle gaps on odd blocks (R4)
    for (int b = 0; b < 16; b++) begin
      drv(K_LCR, b[3:2], 12'h060, 8'h00);
      if (b[0]) begin drv(K_NOP, 0, 0, 0); drv(K_INH, 0, 0, 0); end
      drv(K_ACT, b[3:2], {b[1:0], 10'h0}, 8'h00);
      if (b == 0) chk("R3 seq active no row", row_open, 0);
      if (b[0]) drv(K_NOP, 0, 0, 0);
      drv(K_WR, b[3:2], 12'h000, 8'h01);
      idle_in();
      n = 0; wait_ready(n);
      exp_blk[b] = 1'b1;
      chk("R7 block lock sweep", block_lock, exp_blk);
    end

    // R10 unlock without then with override
    seq3(8'h60, 4'd0, 8'hD0); n = 0; wait_ready(n);
    chk("R10 unlock keeps ends", block_lock, 16'h8001);
    hv_override = 1'b1;
    seq3(8'h60, 4'd0, 8'hD0); n = 0; wait_ready(n);
    hv_override = 1'b0;
    chk("R10 unlock hv clears all", block_lock, 16'h0000);

    // R4 bank mismatch on ACTIVE and on WRITE
    drv(K_LCR, 2'd0, 12'h060, 0); drv(K_ACT, 2'd1, 12'h000, 0); drv(K_WR, 2'd0, 0, 8'h01); idle_in();
    drv(K_NOP, 0, 0, 0);
    chk("R4 active bank mismatch", {status, block_lock}, {8'h80, 16'h0});
    drv(K_LCR, 2'd2, 12'h060, 0); drv(K_ACT, 2'd2, 12'h000, 0); drv(K_WR, 2'd3, 0, 8'h01); idle_in();
    drv(K_NOP, 0, 0, 0);
    chk("R4 write bank mismatch", {status, block_lock}, {8'h80, 16'h0});

    // R5 interrupted by READ
    drv(K_LCR, 2'd0, 12'h060, 0); drv(K_RD, 2'd0, 0, 0);
    drv(K_ACT, 2'd0, 12'h400, 0); drv(K_WR, 2'd0, 0, 8'h01); idle_in();
    drv(K_NOP, 0, 0, 0);
    chk("R5 abandoned seq", {status, block_lock}, {8'h80, 16'h0});

    // R6 bad confirms, then clear (R2)
    seq3(8'h20, 4'd0, 8'h55);
    chk("R6 erase bad confirm", status, 8'hA0);
    seq3(8'h60, 4'd0, 8'h77);
    chk("R6 lock bad confirm", {status, block_lock}, {8'hA0, 16'h0});
    clr_status();
    chk("R2 clear status", status, 8'h80);
    seq3(8'h30, 4'd0, 8'hC0);
    chk("R6 store-mode erase starts", status[7], 0);
    n = 0; wait_ready(n);

    // R11 busy length and drop while busy
    seq3(8'h20, 4'd2, 8'hD0);
    chk("R11 busy after erase", status[7], 0);
    n = 0;
    seq3(8'h60, 4'd6, 8'h01); n = n + 3;
    wait_ready(n);
    chk("R11 busy cycles", n, BUSY);
    chk("R11 dropped while busy", {status, block_lock}, {8'h80, 16'h0});

    // R8 device lock needs override
    seq3(8'h60, 4'd0, 8'hF1);
    chk("R8 refused w/o hv", {status, 7'd0, device_lock}, {8'h90, 8'h00});
    clr_status();
    hv_override = 1'b1;
    seq3(8'h60, 4'd0, 8'hF1); n = 0; wait_ready(n);
    hv_override = 1'b0;
    chk("R8 set with hv", device_lock, 1);

    // R9 refusals under device lock
    seq3(8'h60, 4'd7, 8'h01);
    chk("R9 lock block refused", {status, block_lock}, {8'h90, 16'h0});
    clr_status();
    seq3(8'h20, 4'd3, 8'hD0);
    chk("R9 erase refused", status, 8'h90);
    clr_status();
    hv_override = 1'b1;
    seq3(8'h60, 4'd7, 8'h01); n = 0; wait_ready(n);
    chk("R9 lock block with hv", block_lock, 16'h0080);
    hv_override = 1'b0;
    seq3(8'h60, 4'd0, 8'hD0);
    chk("R9 unlock refused", {status, block_lock}, {8'h90, 16'h0080});
    drv(K_LCR, 2'd0, 12'h070, 8'h00); idle_in();

    // R12 reset mid-state
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R12 reset clears", {status, 6'd0, read_path, 7'd0, device_lock, block_lock},
        {8'h80, 8'h00, 8'h00, 16'h0});

    // R9 block-lock refusal for program, neighbour accepted
    seq3(8'h60, 4'd9, 8'h01); n = 0; wait_ready(n);
    seq3(8'h40, 4'd9, 8'h5A);
    chk("R9 program locked block", {status, block_lock}, {8'h90, 16'h0200});
    clr_status();
    seq3(8'h40, 4'd8, 8'h5A);
    chk("R11 program free block busy", status, 8'h00);
    n = 0; wait_ready(n);
    chk("R11 program busy cycles", n, BUSY);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule